// File: doc/BRIEF.md
# Video Error-Check Packet CRC Verifier and Regenerator

This block sits in a 10-bit digital video word stream that carries an error-check packet once per field. It keeps four running CRC-16 calculators. Two cover the full-field and active-picture windows of the incoming words. The other two cover the same windows of the outgoing words. The incoming results are compared with the CRCs embedded in the received packet, taking the packet's per-region validity bits into account. In the outgoing copy of the packet, the CRC words, validity bits and error flags are rewritten. The inserted CRCs always come from the outgoing stream, so that downstream checkers see values that describe exactly what left the block.

Region timing comes from the surrounding logic as plain strobes: a start-of-field pulse, the two window enables, and a packet-word enable with a word index. Every word passes through a single register stage. Packet words are replaced on their way through that stage; all other words are copied unchanged. A host or flag port can force the outgoing validity bits and replace either region's flag word. The latched CRCs and the received validity bits are exposed as status outputs.

Packet layout, indexed by `pkt_idx`:
- 0: full-field CRC bits 7:0
- 1: full-field CRC bits 15:8 with the validity bit in data bit 8
- 2 and 3: the same pair for active picture
- 4: full-field flag word
- 5: active-picture flag word

Flag word bits are bit 0 error-detected-here, bit 1 error-detected-already, bit 2 unknown-status. All unused data bits are zero.

Top module: `edh_crc_regen`

## Requirements
- R1: A word that is not a packet word (`pkt_en` low) appears unchanged on `dout` one clock later.
- R2: `in_crc_ff` / `in_crc_ap` hold the CRC of the incoming words seen while `ff_win` / `ap_win` was high since the last `sof`. The CRC uses generator x^16+x^12+x^5+1, initial value 0, and takes each word MSB first. The value is latched on the cycle the window closes.
- R3: `out_crc_ff` / `out_crc_ap` hold the same CRC computed over `dout` using the window strobes delayed by one clock.
- R4: Outgoing packet words 0 to 3 carry the outgoing-stream CRCs (low byte in data bits 7:0, high byte in data bits 7:0), with data bit 9 zero. Words 0 and 2 also have data bit 8 zero.
- R5: The outgoing validity bit (data bit 8 of words 1 and 3) is 1 unless `vovr_en[r]` is set. In that case it equals `vovr_val[r]`, with r=0 for full field and r=1 for active picture.
- R6: `rx_valid[0]` / `rx_valid[1]` hold data bit 8 of the last received word 1 / word 3.
- R7: With no flag override, the outgoing error-detected-here bit is 1 only when the received validity bit is 1 and the received CRC differs from the latched incoming CRC.
- R8: With no flag override, the outgoing error-detected-already bit is the OR of the received error-detected-already and error-detected-here bits, whatever the validity bit.
- R9: With no flag override, the outgoing unknown-status bit is the received unknown-status bit OR the inverse of the received validity bit.
- R10: When `fovr_en[r]` is set, the outgoing flag word of region r carries `fovr_flags[3r+2:3r]` in bits 2:0.
- R11: While reset is low, `dout`, all four CRC status outputs and `rx_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 10 | Incoming video word |
| sof | input | 1 | Start-of-field pulse; clears the input-side CRCs |
| ff_win | input | 1 | Incoming word lies in the full-field window |
| ap_win | input | 1 | Incoming word lies in the active-picture window |
| pkt_en | input | 1 | Incoming word belongs to the error-check packet |
| pkt_idx | input | 3 | Index of the packet word (0 to 5) |
| vovr_en | input | 2 | Per-region outgoing validity override enable |
| vovr_val | input | 2 | Per-region forced validity value |
| fovr_en | input | 2 | Per-region flag-word override enable |
| fovr_flags | input | 6 | Forced flag words, full field in 2:0, active picture in 5:3 |
| dout | output | 10 | Outgoing video word |
| in_crc_ff | output | 16 | Latched incoming full-field CRC |
| in_crc_ap | output | 16 | Latched incoming active-picture CRC |
| out_crc_ff | output | 16 | Latched outgoing full-field CRC |
| out_crc_ap | output | 16 | Latched outgoing active-picture CRC |
| rx_valid | output | 2 | Received validity bits, full field in bit 0 |

## Verification
The bench sweeps 128 fields that combine every pattern of received validity bits, correct or corrupted CRCs, and incoming flag bits with a spread of validity and flag overrides. It targets three mistakes:
- If a design compared CRCs while the validity bit was low, it would raise error-detected-here on a packet it should only mark unknown.
- If a design gated error-detected-already on validity, it would drop a flag that upstream stages had raised.
- If a design latched the CRC one word early or late, or seeded the calculator wrongly, every inserted CRC word would differ from the bench's long-division value. The same would happen if it leaked the received CRC into the output packet, since the corrupted fields carry a different value.

// File: rtl/edh_pkg.sv
package edh_pkg;
  localparam int WORD_W = 10;
  localparam int CRC_W  = 16;
  localparam int IDX_W  = 3;
  localparam int N_REG  = 2;   // region 0 = full field, region 1 = active picture
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  // Flag word: bit 0 error-here, bit 1 error-already, bit 2 unknown status
  function automatic logic [2:0] flag_merge(input logic v, input logic mism,
                                            input logic [2:0] fin);
    return {fin[2] | ~v, fin[1] | fin[0], v & mism};
  endfunction
endpackage

// File: rtl/edh_crc_acc.sv
module edh_crc_acc #(
  parameter int DW = 10,
  parameter int CW = 16,
  parameter logic [CW-1:0] POLY = 16'h1021
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic [CW-1:0] hold,
  output logic          latch_evt
);
  logic [CW-1:0] run;
  logic          en_d;

  function automatic logic [CW-1:0] crc_step(input logic [CW-1:0] c, input logic [DW-1:0] w);
    logic [CW-1:0] r;
    logic fb;
    r = c;
    for (int b = DW - 1; b >= 0; b--) begin
      fb = r[CW-1] ^ w[b];
      r  = {r[CW-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return r;
  endfunction

  assign latch_evt = en_d & ~en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= '0;
      en_d <= 1'b0;
      hold <= '0;
    end else begin
      en_d <= en;
      if (clr) run <= '0;
      else if (en) run <= crc_step(run, d);
      if (latch_evt) hold <= run;
    end
  end
endmodule

// File: rtl/edh_rx_capture.sv
module edh_rx_capture #(
  parameter int DW = 10,
  parameter int CW = 16,
  parameter int IW = 3,
  parameter int NR = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pkt_en,
  input  logic [IW-1:0]        pkt_idx,
  input  logic [DW-1:0]        din,
  output logic [NR-1:0][CW-1:0] rx_crc,
  output logic [NR-1:0]        rx_v
);
  localparam int HB = CW / 2;

  for (genvar r = 0; r < NR; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rx_crc[r] <= '0;
        rx_v[r]   <= 1'b0;
      end else if (pkt_en) begin
        if (pkt_idx == IW'(2 * r)) rx_crc[r][HB-1:0] <= din[HB-1:0];
        if (pkt_idx == IW'(2 * r + 1)) begin
          rx_crc[r][CW-1:HB] <= din[HB-1:0];
          rx_v[r]            <= din[HB];
        end
      end
    end
  end
endmodule

// File: rtl/edh_pkt_rewrite.sv
module edh_pkt_rewrite #(
  parameter int DW = 10,
  parameter int CW = 16,
  parameter int IW = 3,
  parameter int NR = 2
) (
  input  logic                  pkt_en,
  input  logic [IW-1:0]         pkt_idx,
  input  logic [DW-1:0]         din,
  input  logic [NR-1:0][CW-1:0] crc_i,
  input  logic [NR-1:0]         vbit_i,
  input  logic [NR-1:0][2:0]    flags_i,
  output logic [DW-1:0]         word_o
);
  localparam int HB = CW / 2;

  always_comb begin
    word_o = din;
    if (pkt_en) begin
      for (int r = 0; r < NR; r++) begin
        if (pkt_idx == IW'(2 * r))
          word_o = {{(DW-HB){1'b0}}, crc_i[r][HB-1:0]};
        else if (pkt_idx == IW'(2 * r + 1))
          word_o = {{(DW-HB-1){1'b0}}, vbit_i[r], crc_i[r][CW-1:HB]};
        else if (pkt_idx == IW'(2 * NR + r))
          word_o = {{(DW-3){1'b0}}, flags_i[r]};
      end
    end
  end
endmodule

// File: rtl/edh_crc_regen.sv
module edh_crc_regen
  import edh_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int CW = CRC_W,
  parameter int IW = IDX_W,
  parameter logic [CW-1:0] POLY = CRC_POLY
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          sof,
  input  logic          ff_win,
  input  logic          ap_win,
  input  logic          pkt_en,
  input  logic [IW-1:0] pkt_idx,
  input  logic [1:0]    vovr_en,
  input  logic [1:0]    vovr_val,
  input  logic [1:0]    fovr_en,
  input  logic [5:0]    fovr_flags,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] in_crc_ff,
  output logic [CW-1:0] in_crc_ap,
  output logic [CW-1:0] out_crc_ff,
  output logic [CW-1:0] out_crc_ap,
  output logic [1:0]    rx_valid
);
  localparam int NR = 2;

  logic [NR-1:0]         win, win_q;
  logic                  sof_q;
  logic [NR-1:0][CW-1:0] in_hold, out_hold, rx_crc;
  logic [NR-1:0]         in_latch, out_latch, rx_v;
  logic [NR-1:0]         mismatch, vbit;
  logic [NR-1:0][2:0]    flags_new;
  logic [DW-1:0]         word_nx;

  assign win = {ap_win, ff_win};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout  <= '0;
      win_q <= '0;
      sof_q <= 1'b0;
    end else begin
      dout  <= word_nx;
      win_q <= win;
      sof_q <= sof;
    end
  end

  for (genvar r = 0; r < NR; r++) begin : g_region
    edh_crc_acc #(.DW(DW), .CW(CW), .POLY(POLY)) u_in (
      .clk(clk), .rst_n(rst_n), .clr(sof), .en(win[r]), .d(din),
      .hold(in_hold[r]), .latch_evt(in_latch[r]));
    edh_crc_acc #(.DW(DW), .CW(CW), .POLY(POLY)) u_out (
      .clk(clk), .rst_n(rst_n), .clr(sof_q), .en(win_q[r]), .d(dout),
      .hold(out_hold[r]), .latch_evt(out_latch[r]));

    assign mismatch[r]  = rx_v[r] & (rx_crc[r] != in_hold[r]);
    assign vbit[r]      = vovr_en[r] ? vovr_val[r] : 1'b1;
    assign flags_new[r] = fovr_en[r] ? fovr_flags[3*r +: 3]
                                     : flag_merge(rx_v[r], mismatch[r], din[2:0]);
  end

  edh_rx_capture #(.DW(DW), .CW(CW), .IW(IW), .NR(NR)) u_rx (
    .clk(clk), .rst_n(rst_n), .pkt_en(pkt_en), .pkt_idx(pkt_idx), .din(din),
    .rx_crc(rx_crc), .rx_v(rx_v));

  edh_pkt_rewrite #(.DW(DW), .CW(CW), .IW(IW), .NR(NR)) u_rw (
    .pkt_en(pkt_en), .pkt_idx(pkt_idx), .din(din), .crc_i(out_hold),
    .vbit_i(vbit), .flags_i(flags_new), .word_o(word_nx));

  assign in_crc_ff  = in_hold[0];
  assign in_crc_ap  = in_hold[1];
  assign out_crc_ff = out_hold[0];
  assign out_crc_ap = out_hold[1];
  assign rx_valid   = rx_v;
endmodule

// File: rtl/edh_crc_regen_chk.sv
module edh_crc_regen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [9:0]  din,
  input logic        pkt_en,
  input logic [2:0]  pkt_idx,
  input logic [1:0]  vovr_en,
  input logic [1:0]  fovr_en,
  input logic [5:0]  fovr_flags,
  input logic [9:0]  dout,
  input logic [15:0] out_crc_ff,
  input logic [1:0]  rx_valid,
  input logic [1:0]  mismatch
);
  a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(pkt_en)) |-> dout == $past(din));

  a_r4_ff_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pkt_en) && $past(pkt_idx) == 3'd0)
      |-> dout[7:0] == $past(out_crc_ff[7:0]));

  a_r5_default_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pkt_en) && $past(pkt_idx) == 3'd3 && !$past(vovr_en[1]))
      |-> dout[8]);

  a_r7_no_edh_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pkt_en) && $past(pkt_idx) == 3'd5 && !$past(fovr_en[1])
      && !$past(rx_valid[1])) |-> !dout[0]);

  a_r7_edh_follows_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pkt_en) && $past(pkt_idx) == 3'd4 && !$past(fovr_en[0]))
      |-> dout[0] == $past(mismatch[0]));

  a_r8_eda_or: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pkt_en) && $past(pkt_idx) == 3'd4 && !$past(fovr_en[0]))
      |-> dout[1] == ($past(din[1]) | $past(din[0])));

  a_r9_ues_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pkt_en) && $past(pkt_idx) == 3'd4 && !$past(fovr_en[0])
      && !$past(rx_valid[0])) |-> dout[2]);

  a_r10_flag_override: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pkt_en) && $past(pkt_idx) == 3'd5 && $past(fovr_en[1]))
      |-> dout[2:0] == $past(fovr_flags[5:3]));
endmodule

bind edh_crc_regen edh_crc_regen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .pkt_en(pkt_en), .pkt_idx(pkt_idx),
  .vovr_en(vovr_en), .fovr_en(fovr_en), .fovr_flags(fovr_flags), .dout(dout),
  .out_crc_ff(out_crc_ff), .rx_valid(rx_valid), .mismatch(mismatch));

// File: tb/tb_edh_crc_regen.sv
`timescale 1ns/1ps
module tb_edh_crc_regen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  din;
  logic        sof, ff_win, ap_win, pkt_en;
  logic [2:0]  pkt_idx;
  logic [1:0]  vovr_en, vovr_val, fovr_en;
  logic [5:0]  fovr_flags;
  logic [9:0]  dout;
  logic [15:0] in_crc_ff, in_crc_ap, out_crc_ff, out_crc_ap;
  logic [1:0]  rx_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  edh_crc_regen dut (
    .clk(clk), .rst_n(rst_n), .din(din), .sof(sof), .ff_win(ff_win), .ap_win(ap_win),
    .pkt_en(pkt_en), .pkt_idx(pkt_idx), .vovr_en(vovr_en), .vovr_val(vovr_val),
    .fovr_en(fovr_en), .fovr_flags(fovr_flags), .dout(dout),
    .in_crc_ff(in_crc_ff), .in_crc_ap(in_crc_ap), .out_crc_ff(out_crc_ff),
    .out_crc_ap(out_crc_ap), .rx_valid(rx_valid));

  // Polynomial long division, one bit at a time, taps written out
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [9:0] w);
    logic [15:0] s;
    logic top;
    s = c;
    for (int b = 9; b >= 0; b--) begin
      top = s[15] ^ w[b];
      s = s << 1;
      if (top) begin s[0] = ~s[0]; s[5] = ~s[5]; s[12] = ~s[12]; end
    end
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    din = '0; sof = 0; ff_win = 0; ap_win = 0; pkt_en = 0; pkt_idx = '0;
  endtask

  task automatic run_field(input int c);
    logic [15:0] eff, eap, tff, tap;
    logic vff, vap, bff, bap;
    logic [2:0] fin_ff, fin_ap, xff, xap;
    logic [9:0] last, pk[6], got[6];
    logic vbo0, vbo1;
    vff = c[0]; vap = c[1]; bff = c[2]; bap = c[3];
    fin_ff = c[6:4]; fin_ap = {c[4], c[6], c[5]};
    vovr_en = {c[6] & c[1], c[5] & c[0]};
    vovr_val = c[3:2];
    fovr_en = {c[6] & c[2] & c[0], c[5] & c[3]};
    fovr_flags = 6'(c * 11);
    eff = '0; eap = '0;
    @(negedge clk); idle(); sof = 1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i > 0) chk("R1 field word", dout, last);
      idle();
      din = 10'((i * 37 + c * 101 + 5) & 10'h3FF);
      ff_win = 1;
      ap_win = (i >= 3 && i <= 8);
      eff = ref_crc(eff, din);
      if (ap_win) eap = ref_crc(eap, din);
      last = din;
    end
    for (int g = 0; g < 4; g++) begin
      @(negedge clk);
      chk("R1 gap word", dout, last);
      idle();
      din = 10'(10'h155 + c + g);
      last = din;
    end
    chk("R2 in ff crc", in_crc_ff, eff);
    chk("R2 in ap crc", in_crc_ap, eap);
    chk("R3 out ff crc", out_crc_ff, eff);
    chk("R3 out ap crc", out_crc_ap, eap);
    tff = bff ? eff ^ 16'h0140 : eff;
    tap = bap ? eap ^ 16'h2001 : eap;
    pk[0] = {2'b00, tff[7:0]}; pk[1] = {1'b0, vff, tff[15:8]};
    pk[2] = {2'b00, tap[7:0]}; pk[3] = {1'b0, vap, tap[15:8]};
    pk[4] = {7'b0, fin_ff};    pk[5] = {7'b0, fin_ap};
    for (int i = 0; i <= 6; i++) begin
      @(negedge clk);
      if (i > 0) got[i-1] = dout;
      idle();
      if (i < 6) begin pkt_en = 1; pkt_idx = 3'(i); din = pk[i]; end
    end
    vbo0 = vovr_en[0] ? vovr_val[0] : 1'b1;
    vbo1 = vovr_en[1] ? vovr_val[1] : 1'b1;
    chk("R4 ff crc low word", got[0], {2'b00, eff[7:0]});
    chk("R4 ff crc high byte", {got[1][9], got[1][7:0]}, {1'b0, eff[15:8]});
    chk("R5 ff validity bit", got[1][8], vbo0);
    chk("R4 ap crc low word", got[2], {2'b00, eap[7:0]});
    chk("R4 ap crc high byte", {got[3][9], got[3][7:0]}, {1'b0, eap[15:8]});
    chk("R5 ap validity bit", got[3][8], vbo1);
    chk("R6 received validity", rx_valid, {vap, vff});
    xff = {fin_ff[2] | ~vff, fin_ff[1] | fin_ff[0], vff & bff};
    xap = {fin_ap[2] | ~vap, fin_ap[1] | fin_ap[0], vap & bap};
    if (fovr_en[0]) chk("R10 ff flag override", got[4], {7'b0, fovr_flags[2:0]});
    else begin
      chk("R7 ff error-here", got[4][0], xff[0]);
      chk("R8 ff error-already", got[4][1], xff[1]);
      chk("R9 ff unknown", got[4][2], xff[2]);
    end
    if (fovr_en[1]) chk("R10 ap flag override", got[5], {7'b0, fovr_flags[5:3]});
    else begin
      chk("R7 ap error-here", got[5][0], xap[0]);
      chk("R8 ap error-already", got[5][1], xap[1]);
      chk("R9 ap unknown", got[5][2], xap[2]);
    end
  endtask

  initial begin
    rst_n = 0; idle();
    vovr_en = '0; vovr_val = '0; fovr_en = '0; fovr_flags = '0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      din = 10'h2A5; ff_win = i[0]; ap_win = i[1];
    end
    @(negedge clk);
    chk("R11 reset dout", dout, 10'h0);
    chk("R11 reset in ff", in_crc_ff, 16'h0);
    chk("R11 reset in ap", in_crc_ap, 16'h0);
    chk("R11 reset out ff", out_crc_ff, 16'h0);
    chk("R11 reset out ap", out_crc_ap, 16'h0);
    chk("R11 reset rx valid", rx_valid, 2'b00);
    idle(); rst_n = 1;
    @(negedge clk);
    for (int c = 0; c < 128; c++) run_field(c);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired got running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule